// File: doc/BRIEF.md
# Video Line and Frame Timing Sequencer

This block derives television line and frame timing from a free-running system clock. A line does not last a whole number of clocks. A fixed-point phase accumulator with 12 fractional bits therefore sets the length of each line in clocks and carries the unused fraction into the next line. Over many lines, the average line period matches the exact ratio.

For every line, the sequencer gives a one-clock line-sync pulse that can drive a timer channel. It also keeps a line index within the frame. It raises a pulse when vertical blanking begins, and a pulse at the wrap to line zero that serves as the frame interrupt. A separate strobe marks every fixed group of lines for the audio engine.

Two standards are supported. A select input chooses between them, and the block samples it only at a frame boundary.

Top module: `vid_timing_seq`

## Requirements
- R1: While reset is asserted, and until the first active clock after the synchronised release, every pulse output is low and the line index is zero. The first frame after reset uses standard 0.
- R2: `hsync_o` is high for exactly one clock at the end of each line. `line_o`, `vblank_o`, `frame_irq_o` and `audio_o` change only in the cycle where `hsync_o` is high.
- R3: Each line lasts floor((f + INC) / 2^12) clocks. Here f is the 12-bit fraction carried in from the previous line and INC is the per-line step of the current standard (8791293 for standard 0, 8864320 for standard 1). The low 12 bits of that sum become the next f. With f = 0 after reset, the first N lines of standard 0 take floor(N·INC/2^12) clocks in total.
- R4: `line_o` steps by one at each line end. It returns to 0 when it would reach the frame's line total: 263 for standard 0, 313 for standard 1.
- R5: `frame_irq_o` pulses together with `hsync_o` at the line end that wraps `line_o` to 0.
- R6: `vblank_o` pulses together with `hsync_o` at the line end where `line_o` becomes the blanking line: 240 for standard 0, 256 for standard 1.
- R7: `audio_o` pulses together with `hsync_o` at every 32nd line end counted from reset. Its line count restarts at each strobe and does not depend on frame boundaries.
- R8: `std_sel` (0 = 60 Hz standard, 1 = 50 Hz standard) is taken only at the line end that wraps the frame. A change in the middle of a frame leaves line lengths and limits untouched until that wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| std_sel | input | 1 | Standard select, 0 = 60 Hz, 1 = 50 Hz |
| hsync_o | output | 1 | One-clock pulse at each line end |
| line_o | output | LINE_W (9) | Line index within the frame |
| vblank_o | output | 1 | Pulse at the start of vertical blanking |
| frame_irq_o | output | 1 | Frame interrupt pulse at the wrap to line 0 |
| audio_o | output | 1 | Audio update strobe |

## Verification
The assertions assume that both per-line steps give lines of at least two clocks, so line-end pulses can never touch. They also assume that both step values plus a full fraction fit the accumulator width. The line-length window check rests on these two assumptions. The bench shrinks the steps to about 5.33 and 9.5 clocks and the frame totals to 7 and 9 lines, so both stay within the assumptions while many frames run. It changes `std_sel` only on falling edges and in the middle of frames, so the behaviour at a frame boundary is exercised.

// File: rtl/vts_pkg.sv
package vts_pkg;
  typedef enum logic {
    STD_60 = 1'b0,
    STD_50 = 1'b1
  } vid_std_e;
endpackage

// File: rtl/vts_rst_sync.sv
module vts_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/vts_line_phase.sv
module vts_line_phase
  import vts_pkg::*;
#(
  parameter int unsigned INC_A  = 8791293,
  parameter int unsigned INC_B  = 8864320,
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned ACC_W  = 24
) (
  input  logic     clk,
  input  logic     rst_n,
  input  vid_std_e std_i,
  output logic     line_end_o
);
  localparam int unsigned LEN_W = ACC_W - FRAC_W;

  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [ACC_W-1:0]  step;
  logic [ACC_W-1:0]  sum;
  logic [LEN_W-1:0]  len;
  logic              last;

  always_comb begin
    step = (std_i == STD_50) ? ACC_W'(INC_B) : ACC_W'(INC_A);
    sum  = step + {{LEN_W{1'b0}}, frac_q};
    len  = sum[ACC_W-1:FRAC_W];
    last = (cnt_q == len - LEN_W'(1));
    frac_d = frac_q;
    cnt_d  = cnt_q + LEN_W'(1);
    if (last) begin
      frac_d = sum[FRAC_W-1:0];
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      cnt_q  <= '0;
    end else begin
      frac_q <= frac_d;
      cnt_q  <= cnt_d;
    end
  end

  assign line_end_o = last;
endmodule

// File: rtl/vts_frame_ctr.sv
module vts_frame_ctr
  import vts_pkg::*;
#(
  parameter int unsigned LINES_A = 263,
  parameter int unsigned VBL_A   = 240,
  parameter int unsigned LINES_B = 313,
  parameter int unsigned VBL_B   = 256,
  parameter int unsigned LINE_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end_i,
  input  logic              std_sel_i,
  output vid_std_e          std_o,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o,
  output logic              frame_o
);
  logic [LINE_W-1:0] line_q, line_d, line_nxt, total, vbl;
  vid_std_e          std_q, std_d;
  logic              vb_q, vb_d, fr_q, fr_d;

  always_comb begin
    total    = (std_q == STD_50) ? LINE_W'(LINES_B) : LINE_W'(LINES_A);
    vbl      = (std_q == STD_50) ? LINE_W'(VBL_B)   : LINE_W'(VBL_A);
    line_nxt = line_q + LINE_W'(1);
    line_d   = line_q;
    std_d    = std_q;
    vb_d     = 1'b0;
    fr_d     = 1'b0;
    if (line_end_i) begin
      if (line_nxt == total) begin
        line_d = '0;
        fr_d   = 1'b1;
        std_d  = vid_std_e'(std_sel_i);
      end else begin
        line_d = line_nxt;
        vb_d   = (line_nxt == vbl);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      std_q  <= STD_60;
      vb_q   <= 1'b0;
      fr_q   <= 1'b0;
    end else begin
      line_q <= line_d;
      std_q  <= std_d;
      vb_q   <= vb_d;
      fr_q   <= fr_d;
    end
  end

  assign std_o    = std_q;
  assign line_o   = line_q;
  assign vblank_o = vb_q;
  assign frame_o  = fr_q;
endmodule

// File: rtl/vts_audio_div.sv
module vts_audio_div #(
  parameter int unsigned AUD_LINES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_end_i,
  output logic strobe_o
);
  localparam int unsigned AUD_W = $clog2(AUD_LINES + 1);

  logic [AUD_W-1:0] cnt_q, cnt_d, cnt_nxt;
  logic             st_q, st_d;

  always_comb begin
    cnt_nxt = cnt_q + AUD_W'(1);
    cnt_d   = cnt_q;
    st_d    = 1'b0;
    if (line_end_i) begin
      if (cnt_nxt == AUD_W'(AUD_LINES)) begin
        cnt_d = '0;
        st_d  = 1'b1;
      end else begin
        cnt_d = cnt_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  assign strobe_o = st_q;
endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
  import vts_pkg::*;
#(
  parameter int unsigned INC_A     = 8791293,
  parameter int unsigned INC_B     = 8864320,
  parameter int unsigned FRAC_W    = 12,
  parameter int unsigned ACC_W     = 24,
  parameter int unsigned LINES_A   = 263,
  parameter int unsigned VBL_A     = 240,
  parameter int unsigned LINES_B   = 313,
  parameter int unsigned VBL_B     = 256,
  parameter int unsigned AUD_LINES = 32,
  localparam int unsigned LINE_W   =
    $clog2(((LINES_A > LINES_B) ? LINES_A : LINES_B) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_sel,
  output logic              hsync_o,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o,
  output logic              frame_irq_o,
  output logic              audio_o
);
  logic     rst_sync_n;
  logic     line_end;
  vid_std_e std_cur;
  logic     hs_q, hs_d;

  vts_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_sync_n)
  );

  vts_line_phase #(
    .INC_A (INC_A),
    .INC_B (INC_B),
    .FRAC_W(FRAC_W),
    .ACC_W (ACC_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .std_i     (std_cur),
    .line_end_o(line_end)
  );

  vts_frame_ctr #(
    .LINES_A(LINES_A),
    .VBL_A  (VBL_A),
    .LINES_B(LINES_B),
    .VBL_B  (VBL_B),
    .LINE_W (LINE_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .line_end_i(line_end),
    .std_sel_i (std_sel),
    .std_o     (std_cur),
    .line_o    (line_o),
    .vblank_o  (vblank_o),
    .frame_o   (frame_irq_o)
  );

  vts_audio_div #(
    .AUD_LINES(AUD_LINES)
  ) u_audio (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .line_end_i(line_end),
    .strobe_o  (audio_o)
  );

  assign hs_d = line_end;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hs_q <= 1'b0;
    else             hs_q <= hs_d;
  end

  assign hsync_o = hs_q;
endmodule

// File: rtl/vts_checker.sv
module vts_checker #(
  parameter int unsigned INC_A   = 8791293,
  parameter int unsigned INC_B   = 8864320,
  parameter int unsigned FRAC_W  = 12,
  parameter int unsigned LINES_A = 263,
  parameter int unsigned VBL_A   = 240,
  parameter int unsigned LINES_B = 313,
  parameter int unsigned VBL_B   = 256,
  parameter int unsigned LINE_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync,
  input logic [LINE_W-1:0] line,
  input logic              vblank,
  input logic              frame,
  input logic              audio,
  input logic              std
);
  localparam int unsigned LEN_LO  = ((INC_A < INC_B) ? INC_A : INC_B) >> FRAC_W;
  localparam int unsigned LEN_HI  = (((INC_A > INC_B) ? INC_A : INC_B) >> FRAC_W) + 1;
  localparam int unsigned MAXLN   = (LINES_A > LINES_B) ? LINES_A : LINES_B;

  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gap_q <= 16'd1;
    else if (hsync) gap_q <= 16'd1;
    else if (gap_q != 16'hffff) gap_q <= gap_q + 16'd1;
  end

  always @(negedge clk) begin
    if (!rst_n)
      assert_reset_quiet_R1: assert (!hsync && !vblank && !frame && !audio && line == '0);
  end

  assert_hsync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> !hsync);

  assert_line_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> (gap_q >= 16'(LEN_LO) && gap_q <= 16'(LEN_HI)));

  assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync |-> $stable(line));

  assert_line_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line < LINE_W'(MAXLN));

  assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> (hsync && line == '0));

  assert_vblank_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> (hsync && line == (std ? LINE_W'(VBL_B) : LINE_W'(VBL_A))));

  assert_audio_on_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    audio |-> hsync);

  assert_std_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |-> $stable(std));
endmodule

bind vid_timing_seq vts_checker #(
  .INC_A  (INC_A),
  .INC_B  (INC_B),
  .FRAC_W (FRAC_W),
  .LINES_A(LINES_A),
  .VBL_A  (VBL_A),
  .LINES_B(LINES_B),
  .VBL_B  (VBL_B),
  .LINE_W (LINE_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .hsync (hsync_o),
  .line  (line_o),
  .vblank(vblank_o),
  .frame (frame_irq_o),
  .audio (audio_o),
  .std   (std_cur)
);

// File: tb/sim_vid_timing_seq.sv
`timescale 1ns/1ps
module sim_vid_timing_seq;
  localparam int INC_A = 21845;
  localparam int INC_B = 38912;
  localparam int LA = 7, VA = 5, LB = 9, VB = 6, AUD = 4;
  localparam int LW = $clog2(10);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic std_sel = 1'b0;
  logic hsync, vblank, frame_irq, audio;
  logic [LW-1:0] line;

  always #5 clk = ~clk;

  vid_timing_seq #(
    .INC_A(INC_A), .INC_B(INC_B), .FRAC_W(12), .ACC_W(24),
    .LINES_A(LA), .VBL_A(VA), .LINES_B(LB), .VBL_B(VB), .AUD_LINES(AUD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel),
    .hsync_o(hsync), .line_o(line), .vblank_o(vblank),
    .frame_irq_o(frame_irq), .audio_o(audio)
  );

  int checks = 0, fails = 0;
  int edges = 0;
  int m_cnt = 0, m_frac = 0, m_line = 0, m_aud = 0, m_std = 0;
  int e_hs = 0, e_fr = 0, e_vb = 0, e_au = 0;
  int cyc = 0, last_hs = 0, gap = 0, n_hs = 0, mon_line = 0, n_fr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int inc, len, tot, vbl;
    inc = m_std ? INC_B : INC_A;
    tot = m_std ? LB : LA;
    vbl = m_std ? VB : VA;
    len = (m_frac + inc) / 4096;
    e_hs = 0; e_fr = 0; e_vb = 0; e_au = 0;
    if (m_cnt == len - 1) begin
      e_hs = 1;
      m_frac = (m_frac + inc) % 4096;
      m_cnt = 0;
      if (m_line + 1 == tot) begin
        m_line = 0; e_fr = 1; m_std = int'(std_sel);
      end else begin
        m_line = m_line + 1;
        if (m_line == vbl) e_vb = 1;
      end
      m_aud = m_aud + 1;
      if (m_aud == AUD) begin m_aud = 0; e_au = 1; end
    end else begin
      m_cnt = m_cnt + 1;
    end
  endtask

  // reference model advances from the first edge after synchronised release
  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else begin
      if (edges >= 2) model_step();
      edges <= edges + 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst_n || edges < 3) begin
      chk("R1 hsync", int'(hsync), 0);
      chk("R1 line", int'(line), 0);
      chk("R1 pulses", int'(vblank | frame_irq | audio), 0);
    end else begin
      chk("R2 hsync", int'(hsync), e_hs);
      chk("R4 line", int'(line), m_line);
      chk("R5 frame_irq", int'(frame_irq), e_fr);
      chk("R6 vblank", int'(vblank), e_vb);
      chk("R7 audio", int'(audio), e_au);
    end
    if (hsync) begin
      gap = cyc - last_hs; last_hs = cyc; n_hs++;
    end
    if (frame_irq) n_fr++;
    mon_line = int'(line);
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int c1, k, f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R3: lines 2..7 of standard 0 after a zero fraction
    while (n_hs < 1) @(posedge clk);
    c1 = last_hs;
    while (n_hs < 7) @(posedge clk);
    chk("R3 six-line span", last_hs - c1, (7 * INC_A) / 4096 - INC_A / 4096);
    repeat (150) @(posedge clk);
    // R8: change standard mid-frame, line after change keeps old length
    while (mon_line != 2) @(posedge clk);
    @(negedge clk) std_sel = 1'b1;
    k = n_hs;
    while (n_hs < k + 2) @(posedge clk);
    chk("R8 mid-frame line short", int'(gap <= INC_A / 4096 + 1), 1);
    f0 = n_fr;
    while (n_fr == f0) @(posedge clk);
    k = n_hs;
    while (n_hs < k + 1) @(posedge clk);
    chk("R8 first line after wrap long", int'(gap >= INC_B / 4096), 1);
    repeat (600) @(posedge clk);
    while (mon_line != 3) @(posedge clk);
    @(negedge clk) std_sel = 1'b0;
    repeat (600) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule